// File: doc/BRIEF.md
# Packet-Aware Graceful Reset Controller

This block owns the single output register of a transmit pipeline whose traffic is framed by start-of-packet and end-of-packet markers. It accepts two reset requests. The first is a bus reset, used when the whole link is going down. The second is a logic reset, raised by the application while the link stays up. From these it drives a synchronous reset for the pipeline, a gate on the upstream ready signal, and a one-cycle completion flag.

A bus reset clears the output stage on the next clock edge, even if a packet is only partly sent. There is no point in keeping the framing intact when the link state is being thrown away. A logic reset is graceful. The packet already in flight keeps moving until its end beat has left the stage, and no new packet may begin. Only then is the stage held in reset.

The reset is held for a set number of cycles. The completion flag then pulses once to tell upstream logic that it may transmit again. The bus reset also serves as the power-on reset, so the block comes up holding the stage cleared and reports completion once before the first packet. The block has no asynchronous reset anywhere.

Top module: `pkt_reset_ctrl`

## Requirements
- R1: When `bus_rst` is sampled high at a clock edge, `out_valid` is low after that edge, even if a packet was partly sent.
- R2: `stage_rst` is high in every cycle in which `bus_rst` is high. While `stage_rst` is high, `up_ready` is low, and the stage is empty after the next edge.
- R3: A logic reset that arrives while a packet is open lets the remaining beats, up to and including the end beat, pass with the normal handshake. `stage_rst` stays low until that end beat has left the stage.
- R4: Once the open packet's end beat has been accepted from upstream, and while the logic reset is still pending, `up_ready` stays low. No new start beat can enter.
- R5: After the last cycle in which a reset request is seen, `stage_rst` stays high for exactly `RST_CYCLES` cycles. `done` is then high for exactly one cycle, after which `stage_rst` and `done` are both low.
- R6: A bus reset that arrives while a logic reset is draining takes effect at once. `stage_rst` goes high in that same cycle, and the stage is cleared at the next edge.
- R7: After the bus reset is released, `done` pulses once before any beat can be accepted. `up_ready` is low until the `done` cycle and is high in the `done` cycle.
- R8: A beat that carries both `up_sop` and `up_eop` does not open a packet. A logic reset that follows such a beat starts the reset with the same timing as an idle logic reset.
- R9: In normal running, `up_ready` equals `!out_valid || down_ready`. An accepted beat appears on the outputs one cycle later, stays there while `down_ready` is low, and leaves on the first edge where `down_ready` is high.
- R10: If `logic_rst` is first sampled at edge k, with no packet open and the stage empty, `stage_rst` is low between edges k and k+1 and high from edge k+1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on its rising edge |
| bus_rst | input | 1 | Link-level reset request; also the power-on reset |
| logic_rst | input | 1 | Graceful reset request from application logic |
| up_valid | input | 1 | Upstream beat valid |
| up_sop | input | 1 | Upstream beat is the first of a packet |
| up_eop | input | 1 | Upstream beat is the last of a packet |
| up_data | input | DATA_W | Upstream beat payload |
| up_ready | output | 1 | Stage accepts the upstream beat this cycle |
| out_valid | output | 1 | Output stage holds a beat |
| out_sop | output | 1 | Held beat is a packet start |
| out_eop | output | 1 | Held beat is a packet end |
| out_data | output | DATA_W | Held beat payload |
| down_ready | input | 1 | Downstream takes the held beat this cycle |
| stage_rst | output | 1 | Synchronous reset for the transmit pipeline |
| done | output | 1 | One-cycle pulse: reset finished, transmission may resume |

## Verification
The bench targets the moments where the two reset kinds must diverge. A bus reset is driven mid-packet. A design that drained first would leave `out_valid` high after the edge. A logic reset is raised mid-packet while `down_ready` stalls the stage. A design that reset early would drop the held beat or the end beat, and one that opened the gate too soon would let a fresh start beat slip in after the end beat. A bus reset is also driven during a drain; a design that ignored it would stay stuck waiting for an end beat. Single-beat packets are tested as well. A tracker that let a start-and-end beat open a packet would never leave the drain.

// File: rtl/prc_pkg.sv
package prc_pkg;

    typedef enum logic [1:0] {
        ST_RUN   = 2'd0,
        ST_DRAIN = 2'd1,
        ST_HOLD  = 2'd2,
        ST_DONE  = 2'd3
    } prc_state_e;

    typedef struct packed {
        logic sop;
        logic eop;
    } prc_frame_t;

    // A beat opens a packet only when it starts one without also ending it.
    function automatic logic opens_packet(input prc_frame_t f);
        return f.sop && !f.eop;
    endfunction

endpackage

// File: rtl/prc_frame_tracker.sv
module prc_frame_tracker
    import prc_pkg::*;
(
    input  logic       clk,
    input  logic       clr,
    input  logic       accept,
    input  prc_frame_t frame,
    output logic       in_pkt
);

    logic open_q;

    always_ff @(posedge clk) begin
        if (clr) begin
            open_q <= 1'b0;
        end else if (accept) begin
            if (frame.eop) begin
                open_q <= 1'b0;
            end else if (opens_packet(frame)) begin
                open_q <= 1'b1;
            end
        end
    end

    assign in_pkt = open_q;

endmodule

// File: rtl/prc_fsm.sv
module prc_fsm
    import prc_pkg::*;
#(
    parameter int RST_CYCLES = 4
) (
    input  logic clk,
    input  logic bus_rst,
    input  logic logic_rst,
    input  logic in_pkt,
    input  logic stage_full,
    output logic stage_rst,
    output logic start_gate,
    output logic done
);

    localparam int CNT_W = $clog2(RST_CYCLES + 1);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(RST_CYCLES - 1);

    prc_state_e       state_q;
    prc_state_e       state_d;
    logic [CNT_W-1:0] cnt_q;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_RUN, ST_DONE: begin
                if (bus_rst)        state_d = ST_HOLD;
                else if (logic_rst) state_d = ST_DRAIN;
                else                state_d = ST_RUN;
            end
            ST_DRAIN: begin
                if (bus_rst)                       state_d = ST_HOLD;
                else if (!in_pkt && !stage_full)   state_d = ST_HOLD;
                else                               state_d = ST_DRAIN;
            end
            ST_HOLD: begin
                if (bus_rst || logic_rst) state_d = ST_HOLD;
                else if (cnt_q == LAST)   state_d = ST_DONE;
                else                      state_d = ST_HOLD;
            end
            default: state_d = ST_HOLD;
        endcase
    end

    always_ff @(posedge clk) begin
        state_q <= state_d;
        if (state_q != ST_HOLD || bus_rst || logic_rst) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign stage_rst  = bus_rst || (state_q == ST_HOLD);
    assign start_gate = !stage_rst && !((state_q == ST_DRAIN) && !in_pkt);
    assign done       = (state_q == ST_DONE);

endmodule

// File: rtl/prc_out_stage.sv
module prc_out_stage
    import prc_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              clr,
    input  logic              load,
    input  prc_frame_t        in_frame,
    input  logic [DATA_W-1:0] in_data,
    input  logic              down_ready,
    output logic              can_take,
    output logic              valid,
    output prc_frame_t        frame,
    output logic [DATA_W-1:0] data
);

    logic              valid_q;
    prc_frame_t        frame_q;
    logic [DATA_W-1:0] data_q;

    always_ff @(posedge clk) begin
        if (clr) begin
            valid_q <= 1'b0;
            frame_q <= '0;
        end else if (load) begin
            valid_q <= 1'b1;
            frame_q <= in_frame;
        end else if (down_ready) begin
            valid_q <= 1'b0;
        end
        if (load) begin
            data_q <= in_data;
        end
    end

    assign can_take = !valid_q || down_ready;
    assign valid    = valid_q;
    assign frame    = frame_q;
    assign data     = data_q;

endmodule

// File: rtl/pkt_reset_ctrl.sv
module pkt_reset_ctrl
    import prc_pkg::*;
#(
    parameter int DATA_W     = 32,
    parameter int RST_CYCLES = 4
) (
    input  logic              clk,
    input  logic              bus_rst,
    input  logic              logic_rst,
    input  logic              up_valid,
    input  logic              up_sop,
    input  logic              up_eop,
    input  logic [DATA_W-1:0] up_data,
    output logic              up_ready,
    output logic              out_valid,
    output logic              out_sop,
    output logic              out_eop,
    output logic [DATA_W-1:0] out_data,
    input  logic              down_ready,
    output logic              stage_rst,
    output logic              done
);

    prc_frame_t in_frame;
    prc_frame_t held_frame;
    logic       in_pkt;
    logic       gate;
    logic       can_take;
    logic       accept;
    logic       rst_w;

    assign in_frame = '{sop: up_sop, eop: up_eop};
    assign up_ready = can_take && gate;
    assign accept   = up_valid && up_ready;

    prc_fsm #(
        .RST_CYCLES (RST_CYCLES)
    ) u_fsm (
        .clk        (clk),
        .bus_rst    (bus_rst),
        .logic_rst  (logic_rst),
        .in_pkt     (in_pkt),
        .stage_full (out_valid),
        .stage_rst  (rst_w),
        .start_gate (gate),
        .done       (done)
    );

    prc_frame_tracker u_track (
        .clk    (clk),
        .clr    (rst_w),
        .accept (accept),
        .frame  (in_frame),
        .in_pkt (in_pkt)
    );

    prc_out_stage #(
        .DATA_W (DATA_W)
    ) u_stage (
        .clk        (clk),
        .clr        (rst_w),
        .load       (accept),
        .in_frame   (in_frame),
        .in_data    (up_data),
        .down_ready (down_ready),
        .can_take   (can_take),
        .valid      (out_valid),
        .frame      (held_frame),
        .data       (out_data)
    );

    assign out_sop   = held_frame.sop;
    assign out_eop   = held_frame.eop;
    assign stage_rst = rst_w;

endmodule

// File: rtl/pkt_reset_ctrl_chk.sv
module pkt_reset_ctrl_chk (
    input logic clk,
    input logic bus_rst,
    input logic up_ready,
    input logic out_valid,
    input logic down_ready,
    input logic stage_rst,
    input logic done
);

    assert_rst_blocks_ready_R2: assert property (@(posedge clk) disable iff (bus_rst)
        stage_rst |-> !up_ready);

    assert_rst_empties_stage_R2: assert property (@(posedge clk) disable iff (bus_rst)
        stage_rst |=> !out_valid);

    assert_clean_entry_R3: assert property (@(posedge clk) disable iff (bus_rst)
        (stage_rst && !$past(stage_rst)) |-> !$past(out_valid));

    assert_done_one_cycle_R5: assert property (@(posedge clk) disable iff (bus_rst)
        done |=> !done);

    assert_done_after_rst_R5: assert property (@(posedge clk) disable iff (bus_rst)
        done |-> $past(stage_rst));

    assert_ready_rule_R9: assert property (@(posedge clk) disable iff (bus_rst)
        up_ready |-> (!out_valid || down_ready));

endmodule

bind pkt_reset_ctrl pkt_reset_ctrl_chk u_chk (
    .clk        (clk),
    .bus_rst    (bus_rst),
    .up_ready   (up_ready),
    .out_valid  (out_valid),
    .down_ready (down_ready),
    .stage_rst  (stage_rst),
    .done       (done)
);

// File: tb/tb_pkt_reset_ctrl.sv
module tb_pkt_reset_ctrl;

    localparam int DATA_W     = 32;
    localparam int RST_CYCLES = 4;

    logic              clk = 1'b0;
    logic              bus_rst, logic_rst, up_valid, up_sop, up_eop, down_ready;
    logic [DATA_W-1:0] up_data;
    logic              up_ready, out_valid, out_sop, out_eop, stage_rst, done;
    logic [DATA_W-1:0] out_data;

    int errors = 0;
    int checks = 0;

    always #5 clk = ~clk;

    pkt_reset_ctrl #(.DATA_W(DATA_W), .RST_CYCLES(RST_CYCLES)) dut (
        .clk(clk), .bus_rst(bus_rst), .logic_rst(logic_rst),
        .up_valid(up_valid), .up_sop(up_sop), .up_eop(up_eop), .up_data(up_data),
        .up_ready(up_ready), .out_valid(out_valid), .out_sop(out_sop),
        .out_eop(out_eop), .out_data(out_data), .down_ready(down_ready),
        .stage_rst(stage_rst), .done(done)
    );

    // vector: valid sop eop data[7:0] down_ready | exp_ready exp_ovalid exp_data[7:0]
    localparam logic [21:0] VECS [0:7] = '{
        {3'b110, 8'hA1, 1'b1, 1'b1, 1'b1, 8'hA1},
        {3'b100, 8'hA2, 1'b0, 1'b0, 1'b1, 8'hA1},
        {3'b100, 8'hA2, 1'b1, 1'b1, 1'b1, 8'hA2},
        {3'b101, 8'hA3, 1'b1, 1'b1, 1'b1, 8'hA3},
        {3'b000, 8'h00, 1'b1, 1'b1, 1'b0, 8'h00},
        {3'b111, 8'hB1, 1'b0, 1'b1, 1'b1, 8'hB1},
        {3'b000, 8'h00, 1'b0, 1'b0, 1'b1, 8'hB1},
        {3'b000, 8'h00, 1'b1, 1'b1, 1'b0, 8'h00}
    };

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic send(input logic s, input logic e, input logic [7:0] d);
        up_valid = 1'b1; up_sop = s; up_eop = e; up_data = {24'h0, d};
    endtask

    // Count stage_rst cycles from now, then expect the done pulse.
    task automatic wait_reset(input string tag);
        int n = 0;
        #1;
        while (stage_rst && n < 100) begin
            n++;
            tick();
            #1;
        end
        check({tag, " R5 hold length"}, n, RST_CYCLES);
        check({tag, " R5 done high"}, done, 1'b1);
        check({tag, " R7 ready in done cycle"}, up_ready, 1'b1);
        tick();
        #1;
        check({tag, " R5 done drops"}, done, 1'b0);
        check({tag, " R5 stage_rst low"}, stage_rst, 1'b0);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        bus_rst = 1'b1; logic_rst = 1'b0; up_valid = 1'b0; up_sop = 1'b0;
        up_eop = 1'b0; up_data = '0; down_ready = 1'b1;
        repeat (3) tick();
        #1;
        check("R2 stage_rst under bus reset", stage_rst, 1'b1);
        check("R2 ready low under bus reset", up_ready, 1'b0);
        check("R1 stage empty at reset", out_valid, 1'b0);
        check("R7 no done while bus reset", done, 1'b0);
        bus_rst = 1'b0;
        wait_reset("power-up");

        // R9: table of pass-through vectors in normal running
        for (int i = 0; i < 8; i++) begin
            logic [21:0] v;
            v = VECS[i];
            up_valid = v[21]; up_sop = v[20]; up_eop = v[19];
            up_data = {24'h0, v[18:11]}; down_ready = v[10];
            #1;
            check($sformatf("R9 vec%0d up_ready", i), up_ready, v[9]);
            tick();
            #1;
            check($sformatf("R9 vec%0d out_valid", i), out_valid, v[8]);
            if (v[8]) check($sformatf("R9 vec%0d out_data", i), out_data, {24'h0, v[7:0]});
        end

        // R1: bus reset mid-packet
        down_ready = 1'b1;
        send(1'b1, 1'b0, 8'hC1);
        tick();
        send(1'b0, 1'b0, 8'hC2);
        bus_rst = 1'b1;
        #1;
        check("R2 stage_rst with bus", stage_rst, 1'b1);
        check("R2 ready gated", up_ready, 1'b0);
        tick();
        #1;
        check("R1 mid-packet cut", out_valid, 1'b0);
        up_valid = 1'b0;
        bus_rst = 1'b0;
        wait_reset("R1 recover");

        // R3/R4: graceful logic reset mid-packet with a stall
        send(1'b1, 1'b0, 8'hD1);
        tick();
        send(1'b0, 1'b0, 8'hD2);
        logic_rst = 1'b1;
        #1;
        check("R3 mid beat accepted", up_ready, 1'b1);
        tick();
        logic_rst = 1'b0;
        down_ready = 1'b0;
        send(1'b0, 1'b1, 8'hD3);
        #1;
        check("R3 no reset while open", stage_rst, 1'b0);
        tick();
        #1;
        check("R3 held beat kept", out_data, 32'hD2);
        check("R3 held beat valid", out_valid, 1'b1);
        down_ready = 1'b1;
        #1;
        check("R3 end beat accepted", up_ready, 1'b1);
        tick();
        send(1'b1, 1'b0, 8'hE1);
        #1;
        check("R4 start blocked", up_ready, 1'b0);
        check("R3 end beat on output", out_data, 32'hD3);
        check("R3 end beat eop", out_eop, 1'b1);
        check("R3 no reset before end leaves", stage_rst, 1'b0);
        tick();
        #1;
        check("R4 start still blocked", up_ready, 1'b0);
        check("R3 reset waits one more edge", stage_rst, 1'b0);
        tick();
        up_valid = 1'b0;
        wait_reset("R3 graceful");

        // R6: bus reset while draining
        send(1'b1, 1'b0, 8'hF1);
        tick();
        up_valid = 1'b0;
        logic_rst = 1'b1;
        down_ready = 1'b0;
        tick();
        logic_rst = 1'b0;
        #1;
        check("R3 draining no reset", stage_rst, 1'b0);
        bus_rst = 1'b1;
        #1;
        check("R6 immediate stage_rst", stage_rst, 1'b1);
        tick();
        #1;
        check("R6 stage cleared", out_valid, 1'b0);
        bus_rst = 1'b0;
        down_ready = 1'b1;
        wait_reset("R6 recover");

        // R8: single-beat packet does not open a packet
        down_ready = 1'b0;
        send(1'b1, 1'b1, 8'h51);
        tick();
        up_valid = 1'b0;
        logic_rst = 1'b1;
        down_ready = 1'b1;
        tick();
        logic_rst = 1'b0;
        #1;
        check("R8 first edge no reset", stage_rst, 1'b0);
        tick();
        #1;
        check("R8 reset after single beat", stage_rst, 1'b1);
        wait_reset("R8 recover");

        // R10: idle logic reset timing
        logic_rst = 1'b1;
        tick();
        logic_rst = 1'b0;
        #1;
        check("R10 low after edge k", stage_rst, 1'b0);
        tick();
        #1;
        check("R10 high from edge k+1", stage_rst, 1'b1);
        wait_reset("R10 recover");

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule